// File: doc/BRIEF.md
# SPI master controller with tagged characters

This block is a serial peripheral interface master that software drives through a small register window. One character of 8, 16, 24 or 32 bits is moved per transfer. Each character carries a two-bit channel tag, which picks one of four active-low chip selects, and an end-of-frame marker. The chip select of the tagged channel is held low from word to word. It is released only after a word that carries the end-of-frame marker. When a word completes, its tag and marker are copied into a receive-control register next to the received data, so software can match each reply to the request that produced it.

Software sets the clock polarity, clock phase, character length and a power-of-two rate code. It writes the tag and marker, then writes the transmit data, which starts the transfer. It polls the busy bit and the ready flags, or takes the interrupt line, and then reads the result. Error flags for a dropped transmit word and for an overwritten receive word are cleared by writing one to them.

The sequencer has three states. IDLE waits for a transmit-data write. RUN covers every half-bit slot up to the last clock edge. TAIL is one extra half-bit with the serial clock at its idle level. The transitions are: start (IDLE to RUN, on a transmit-data write while enabled), last edge (RUN to TAIL), tail end (TAIL to IDLE, where the word is delivered) and abort (RUN or TAIL to IDLE, when the enable bit is cleared).

Top module: `spim_ctrl`

## Requirements
- R1: After reset the rate code reads 1, status reads 0, interrupt status reads 0x0A (bits 3 and 1 set), all chip selects are high, the serial clock is 0 and the interrupt line is low.
- R2: The configuration register at 0x40 reads back its fields: enable bit 31, polarity bit 14, phase bit 13, master enable bit 11 and length code bits 1:0. The rate register at 0x48 reads back its 3-bit code.
- R3: A write to 0x50 while enabled and idle starts a transfer. Status bit 1 (busy) reads 1 for h*(2N+1) clocks after the write edge, where N is the character length and h = 2^(code-1) clocks (code 0 behaves like code 1). It then reads 0.
- R4: The serial clock idles at the polarity bit and toggles once per half-bit. Data goes out MSB first. With phase 0, MOSI changes on trailing edges and MISO is sampled on leading edges. With phase 1, MOSI changes on leading edges after the first, and MISO is sampled on trailing edges.
- R5: Length code 0/1/2/3 selects 8/16/24/32 bits. The received character is right-aligned in 0x58.
- R6: Transmit control at 0x4C holds the channel tag in bits 1:0 and end-of-frame in bit 2. cs_n[tag] goes low on the starting write edge. It stays low after a word with bit 2 at 0. It goes high at tail end after a word with bit 2 at 1. At most one chip select is low at any time.
- R7: At tail end, receive control at 0x54 shows the sent tag in bits 1:0 and end-of-frame in bit 2, and interrupt status bit 2 (receive data present) sets. Reading 0x58 clears bit 2.
- R8: A word delivered while bit 2 is still set overwrites the data and sets bit 6 (receive overrun). Writing 1 to bits 7..4 of 0x68 clears them.
- R9: A write to 0x50 during a transfer is dropped, the transfer in flight is not disturbed, and bit 7 (transmit dropped) sets.
- R10: With enable at 0, the serial clock sits at the polarity level, all chip selects are high and writes to 0x50 start nothing.
- R11: irq is the OR of interrupt status (0x68) ANDed with interrupt enable (0x6C).
- R12: The FIFO config registers at 0x5C (transmit) and 0x64 (receive) keep a 2-bit threshold in bits 5:4. Their bits 3:0 report buffer fill: transmit = busy, receive = data present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for read side effects) |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_NUM | Active-low chip selects |

## Verification
The sequencer leaves IDLE on the write edge, so the first half-bit slot is visible at the falling clock right after that write. Slot s then occupies clocks s*h through s*h+h-1. Busy, data present, the receive registers and the chip-select release all change together, h*(2N+1) clocks after the write edge. The bench keeps a behavioural model of slot, bit index and expected levels. Each clock it drives MISO for the current slot and compares sclk, mosi, cs_n and the combinational busy bit half a cycle after the edge. Register effects of a write or read are checked from the next falling edge on.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } spim_state_e;

    localparam logic [7:0] OFS_CFG   = 8'h40;
    localparam logic [7:0] OFS_STAT  = 8'h44;
    localparam logic [7:0] OFS_RATE  = 8'h48;
    localparam logic [7:0] OFS_TXC   = 8'h4C;
    localparam logic [7:0] OFS_TXD   = 8'h50;
    localparam logic [7:0] OFS_RXC   = 8'h54;
    localparam logic [7:0] OFS_RXD   = 8'h58;
    localparam logic [7:0] OFS_TXFC  = 8'h5C;
    localparam logic [7:0] OFS_RXFC  = 8'h64;
    localparam logic [7:0] OFS_ISTAT = 8'h68;
    localparam logic [7:0] OFS_IEN   = 8'h6C;

endpackage

// File: rtl/spim_tick.sv
// Half-bit timer: slot_end pulses on the last clock of each half-bit slot.
module spim_tick #(
    parameter int RATE_W = 3,
    localparam int CNT_W = (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              slot_end
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // half-bit = 2^(rate-1) clocks; rate 0 is clamped to one clock
    assign lim = (rate == '0) ? '0
               : (CNT_W'(1) << (rate - RATE_W'(1))) - CNT_W'(1);
    assign slot_end = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!run || slot_end)  cnt_q <= '0;
        else                        cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/spim_shift.sv
// Transmit and receive shift registers, MSB first.
module spim_shift #(
    parameter int LEN_W = 2,
    localparam int WORD_W = 8 << LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              shift_out,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [LEN_W+2:0]  align;

    // left-justify the character: unused bits = (max code - code) bytes
    assign align   = {~len_code, 3'b000};
    assign mosi    = tx_q[WORD_W-1];
    assign rx_word = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_data << align;
            rx_q <= '0;
        end else begin
            if (shift_out) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            if (sample)    rx_q <= {rx_q[WORD_W-2:0], miso};
        end
    end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CS_NUM = 4,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_NUM-1:0] cs_n
);
    localparam int CH_W  = $clog2(CS_NUM);
    localparam int LEN_W = 2;
    localparam int SL_W  = $clog2(2 * (8 << LEN_W));

    spim_state_e state, state_nx;

    logic              cfg_en, cfg_cpol, cfg_cpha, cfg_mst;
    logic [LEN_W-1:0]  cfg_len, cur_len;
    logic [RATE_W-1:0] rate;
    logic [CH_W-1:0]   tx_ch, rx_ch, cur_ch;
    logic              tx_eof, rx_eof, cur_eof;
    logic [31:0]       rx_data_q, rx_word;
    logic [1:0]        tx_thr, rx_thr;
    logic              err_tx, err_rx, rx_full;
    logic [7:0]        ien, istat;
    logic [SL_W-1:0]   sl;
    logic              act;
    logic [CS_NUM-1:0] cs_q;

    logic wr_txd, start, drop, slot_end, edge_run, lead;
    logic shift_en, sample_en, last_slot, done, rd_clr, tx_rdy;

    assign wr_txd    = bus_wr && (bus_addr == ADDR_W'(OFS_TXD));
    assign start     = wr_txd && cfg_en && (state == ST_IDLE);
    assign drop      = wr_txd && cfg_en && (state != ST_IDLE);
    assign edge_run  = (state == ST_RUN) && slot_end;
    assign lead      = ~sl[0];
    assign shift_en  = edge_run && (cfg_cpha ? (lead && (sl != '0)) : !lead);
    assign sample_en = edge_run && (cfg_cpha ? !lead : lead);
    assign last_slot = (sl == SL_W'({cur_len, 4'hF}));
    assign done      = (state == ST_TAIL) && slot_end && cfg_en;
    assign rd_clr    = bus_rd && (bus_addr == ADDR_W'(OFS_RXD));
    assign tx_rdy    = (state == ST_IDLE);

    spim_tick #(.RATE_W(RATE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE),
        .rate(rate), .slot_end(slot_end)
    );

    spim_shift #(.LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(start), .load_data(bus_wdata),
        .len_code(cfg_len), .shift_out(shift_en), .sample(sample_en),
        .miso(miso), .mosi(mosi), .rx_word(rx_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: start, last edge, tail end, abort
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN: begin
                if (!cfg_en)                     state_nx = ST_IDLE;
                else if (slot_end && last_slot)  state_nx = ST_TAIL;
            end
            ST_TAIL: if (!cfg_en || slot_end)  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // software-written settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {cfg_en, cfg_cpol, cfg_cpha, cfg_mst} <= '0;
            cfg_len <= '0;
            rate    <= RATE_W'(1);
            tx_ch   <= '0;
            tx_eof  <= 1'b0;
            tx_thr  <= '0;
            rx_thr  <= '0;
            ien     <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_CFG): begin
                    cfg_en   <= bus_wdata[31];
                    cfg_cpol <= bus_wdata[14];
                    cfg_cpha <= bus_wdata[13];
                    cfg_mst  <= bus_wdata[11];
                    cfg_len  <= bus_wdata[LEN_W-1:0];
                end
                ADDR_W'(OFS_RATE): rate <= bus_wdata[RATE_W-1:0];
                ADDR_W'(OFS_TXC): begin
                    tx_ch  <= bus_wdata[CH_W-1:0];
                    tx_eof <= bus_wdata[CH_W];
                end
                ADDR_W'(OFS_TXFC): tx_thr <= bus_wdata[5:4];
                ADDR_W'(OFS_RXFC): rx_thr <= bus_wdata[5:4];
                ADDR_W'(OFS_IEN):  ien    <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    // sequencer outputs and delivered word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl <= '0; act <= 1'b0; cs_q <= '0;
            cur_ch <= '0; cur_eof <= 1'b0; cur_len <= '0;
            rx_ch <= '0; rx_eof <= 1'b0; rx_data_q <= '0;
            rx_full <= 1'b0; err_tx <= 1'b0; err_rx <= 1'b0;
        end else begin
            if (bus_wr && (bus_addr == ADDR_W'(OFS_ISTAT))) begin
                if (bus_wdata[7]) err_tx <= 1'b0;
                if (bus_wdata[6]) err_rx <= 1'b0;
            end
            if (drop) err_tx <= 1'b0 | 1'b1;
            if (rd_clr) rx_full <= 1'b0;
            if (start) begin
                sl      <= '0;
                act     <= 1'b0;
                cur_ch  <= tx_ch;
                cur_eof <= tx_eof;
                cur_len <= cfg_len;
                cs_q    <= CS_NUM'(1) << tx_ch;
            end
            if (edge_run) begin
                sl  <= sl + SL_W'(1);
                act <= ~act;
            end
            if (done) begin
                rx_data_q <= rx_word;
                rx_ch     <= cur_ch;
                rx_eof    <= cur_eof;
                rx_full   <= 1'b1;
                if (rx_full && !rd_clr) err_rx <= 1'b1;
                if (cur_eof) cs_q <= '0;
            end
            if (!cfg_en) cs_q <= '0;
        end
    end

    assign sclk  = cfg_cpol ^ ((state == ST_RUN) && act);
    assign cs_n  = cfg_en ? ~cs_q : '1;
    assign istat = {err_tx, err_rx, 2'b00, tx_rdy, rx_full, tx_rdy, rx_full};
    assign irq   = |(istat & ien);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CFG):   bus_rdata = {cfg_en, 16'd0, cfg_cpol, cfg_cpha, 1'b0,
                                             cfg_mst, 9'd0, cfg_len};
            ADDR_W'(OFS_STAT):  bus_rdata = {30'd0, !tx_rdy, 1'b0};
            ADDR_W'(OFS_RATE):  bus_rdata = 32'(rate);
            ADDR_W'(OFS_TXC):   bus_rdata = 32'({tx_eof, tx_ch});
            ADDR_W'(OFS_RXC):   bus_rdata = 32'({rx_eof, rx_ch});
            ADDR_W'(OFS_RXD):   bus_rdata = rx_data_q;
            ADDR_W'(OFS_TXFC):  bus_rdata = {26'd0, tx_thr, 3'd0, !tx_rdy};
            ADDR_W'(OFS_RXFC):  bus_rdata = {26'd0, rx_thr, 3'd0, rx_full};
            ADDR_W'(OFS_ISTAT): bus_rdata = {24'd0, istat};
            ADDR_W'(OFS_IEN):   bus_rdata = {24'd0, ien};
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
    import spim_pkg::*;
#(
    parameter int CS_NUM = 4
) (
    input logic              clk,
    input logic              rst_n,
    input spim_state_e       state,
    input logic              slot_end,
    input logic              sclk,
    input logic              cfg_en,
    input logic              cfg_cpol,
    input logic [CS_NUM-1:0] cs_n,
    input logic              done,
    input logic              rx_full,
    input logic              rd_clr,
    input logic              err_rx,
    input logic              drop,
    input logic              err_tx
);
    // R6: never more than one chip select low
    a_r6_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R6: a chip select is low for every shifting slot
    a_r6_cs_held_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cfg_en) |-> (cs_n != '1));

    // R4: serial clock only moves at a half-bit boundary
    a_r4_sclk_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN && !$past(slot_end)
         && $stable(cfg_cpol)) |-> $stable(sclk));

    // R4: serial clock moves at each half-bit boundary inside RUN
    a_r4_sclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN && $past(slot_end)
         && $stable(cfg_cpol)) |-> !$stable(sclk));

    // R8: overwriting an unread word raises overrun
    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full && !rd_clr) |=> err_rx);

    // R9: a dropped transmit write raises its flag
    a_r9_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err_tx);
endmodule

bind spim_ctrl spim_ctrl_chk #(.CS_NUM(CS_NUM)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .slot_end(slot_end),
    .sclk(sclk), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cs_n(cs_n),
    .done(done), .rx_full(rx_full), .rd_clr(rd_clr), .err_rx(err_rx),
    .drop(drop), .err_tx(err_tx)
);

// File: tb/spim_ctrl_test.sv
`timescale 1ns/1ps
module spim_ctrl_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, miso = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sclk, mosi;
    logic [3:0]  cs_n;

    int checks = 0, fails = 0;
    int m_cpol = 0, m_cpha = 0, m_len = 0, m_rate = 1;

    spim_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic setup(input int en, input int cpol, input int cpha, input int len, input int rate);
        bus_write(8'h40, {en[0], 16'd0, cpol[0], cpha[0], 1'b0, 1'b1, 9'd0, len[1:0]});
        bus_write(8'h48, 32'(rate[2:0]));
        m_cpol = cpol; m_cpha = cpha; m_len = len; m_rate = rate;
    endtask

    // one word, compared clock by clock against the slot model
    task automatic xfer(input logic [31:0] data, input logic [31:0] resp,
                        input int ch, input int eof);
        int n, h, t;
        logic [3:0] cs_on;
        n = 8 * (m_len + 1);
        h = (m_rate == 0) ? 1 : (1 << (m_rate - 1));
        t = h * (2 * n + 1);
        cs_on = ~(4'b0001 << ch);
        bus_write(8'h4C, {29'd0, eof[0], ch[1:0]});
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h50; bus_wdata = data;
        miso = resp[n-1];
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 8'h44;
        for (int k = 0; k < t; k++) begin
            int s, idx;
            s = k / h;
            idx = (m_cpha != 0) ? ((s == 0) ? 0 : (s - 1) / 2) : s / 2;
            if (idx > n - 1) idx = n - 1;
            miso = resp[n-1-idx];
            #1;
            chk("R4 sclk level", 32'(sclk), 32'(m_cpol[0] ^ (s % 2 == 1)));
            chk("R6 cs during word", 32'(cs_n), 32'(cs_on));
            if (s < 2 * n) chk("R4 R5 mosi bit", 32'(mosi), 32'(data[n-1-idx]));
            chk("R3 busy during word", 32'(bus_rdata[1]), 32'd1);
            @(negedge clk);
        end
        #1;
        chk("R3 busy clears on time", 32'(bus_rdata[1]), 32'd0);
        chk("R6 cs after word", 32'(cs_n), (eof != 0) ? 32'hF : 32'(cs_on));
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] mask(input int len);
        return (len == 3) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (len + 1))) - 32'd1);
    endfunction

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #750000;
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 cs reset", 32'(cs_n), 32'hF);
        chk("R1 sclk reset", 32'(sclk), 32'd0);
        chk("R1 irq reset", 32'(irq), 32'd0);
        bus_read(8'h48, d); chk("R1 rate reset", d, 32'd1);
        bus_read(8'h44, d); chk("R1 status reset", d, 32'd0);
        bus_read(8'h68, d); chk("R1 istat reset", d, 32'h0A);

        // R2 readback
        bus_write(8'h40, 32'h8000_6803);
        bus_read(8'h40, d); chk("R2 config readback", d, 32'h8000_6803);
        bus_write(8'h48, 32'd5);
        bus_read(8'h48, d); chk("R2 rate readback", d, 32'd5);

        // R3 R4 R5 R6 R7: mode 0, 8 bits, fastest
        setup(1, 0, 0, 0, 1);
        xfer(32'hA5, 32'h3C, 2, 1);
        bus_read(8'h68, d); chk("R7 rx flag set", d, 32'h0F);
        bus_read(8'h54, d); chk("R7 rx ctrl echo", d, 32'h6);
        bus_read(8'h58, d); chk("R5 rx data 8b", d, 32'h3C);
        bus_read(8'h68, d); chk("R7 rx flag cleared by read", d, 32'h0A);

        // mode 3, 16 bits, h=4, two words in one frame, no read between: R6 R8
        setup(1, 1, 1, 1, 3);
        xfer(32'h1234, 32'hBEEF, 1, 0);
        xfer(32'h5678, 32'hC0DE, 1, 1);
        bus_read(8'h54, d); chk("R7 rx ctrl eof echo", d, 32'h5);
        bus_read(8'h58, d); chk("R8 overwritten rx data", d, 32'hC0DE);
        bus_read(8'h68, d); chk("R8 overrun flag", d, 32'h4A);
        bus_write(8'h68, 32'hC0);
        bus_read(8'h68, d); chk("R8 write-one clear", d, 32'h0A);

        // mode 1, 24 bits, rate code 0
        setup(1, 0, 1, 2, 0);
        xfer(32'h00C3_5A96, 32'h0081_7E24, 0, 1);
        bus_read(8'h58, d); chk("R5 rx data 24b", d, 32'h0081_7E24 & mask(2));

        // mode 2, 32 bits, h=2; leave rx unread for R12
        setup(1, 1, 0, 3, 2);
        xfer(32'hDEAD_BEEF, 32'h1357_9BDF, 3, 1);
        bus_write(8'h64, 32'h30);
        bus_read(8'h64, d); chk("R12 rx fifo cfg full", d, 32'h31);
        bus_write(8'h5C, 32'h20);
        bus_read(8'h5C, d); chk("R12 tx fifo cfg idle", d, 32'h20);
        bus_read(8'h58, d); chk("R5 rx data 32b", d, 32'h1357_9BDF);
        bus_read(8'h64, d); chk("R12 rx fifo cfg empty", d, 32'h30);

        // R9: second write during a transfer is dropped
        setup(1, 0, 0, 2, 0);
        miso = 1'b1;
        bus_write(8'h4C, 32'h4);
        bus_write(8'h50, 32'h11_2233);
        bus_read(8'h5C, d); chk("R12 tx fill busy", d, 32'h21);
        bus_write(8'h50, 32'h44_5566);
        repeat (80) @(negedge clk);
        bus_read(8'h68, d); chk("R9 drop flag", d, 32'h8F);
        bus_read(8'h58, d); chk("R9 first word kept", d, 32'h00FF_FFFF);

        // R11 interrupt
        bus_write(8'h6C, 32'h80);
        #1 chk("R11 irq on enabled flag", 32'(irq), 32'd1);
        bus_write(8'h68, 32'h80);
        #1 chk("R11 irq off after clear", 32'(irq), 32'd0);
        bus_write(8'h6C, 32'h08);
        #1 chk("R11 irq on tx ready", 32'(irq), 32'd1);
        bus_write(8'h6C, 32'h00);

        // R10 disabled
        setup(0, 1, 0, 0, 1);
        #1;
        chk("R10 sclk at polarity", 32'(sclk), 32'd1);
        chk("R10 cs high", 32'(cs_n), 32'hF);
        bus_write(8'h50, 32'h99);
        #1 chk("R10 cs still high", 32'(cs_n), 32'hF);
        bus_read(8'h44, d); chk("R10 no transfer started", d, 32'd0);
        bus_read(8'h68, d); chk("R10 no drop flag", d, 32'h0A);

        summary();
        $finish;
    end
endmodule